// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets clocked logic read and write an external asynchronous static RAM of 32768 bytes. A single request port takes an address, write data and a direction flag. The controller then drives the memory's active-low chip select, write enable and output enable, its address bus and a split bidirectional data bus (driven value, driver enable and sampled value). Every phase of an access lasts a fixed number of clock cycles. These counts are worked out at elaboration time from the clock period and the memory's speed grade, rounding each nanosecond limit up to whole cycles.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. While `req_ready` is low, the requester must hold `req_valid` and the request fields steady. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle with the read byte, and the consumer must take it in that cycle. When no request is pending, chip select stays high so the memory rests in standby.

Writes drive the address and data one cycle before write enable falls. They hold both for at least one cycle after it rises, and output enable stays high throughout. Reads release the data drivers and then hold chip select and output enable low for the full access count. After a read, the controller waits out the memory's output-release time before its own drivers may turn on again.

Top module: `asram_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select, write enable and output enable are high, the data driver enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: While no request is presented, chip select stays high and `req_ready` stays high.
- R3: A byte written to an address is returned by a later read of that address, at any address from 0x0000 to 0x7FFF. A newer write to the same address replaces the older byte.
- R4: The write strobe (chip select and write enable both low) lasts at least ceil(40 ns / clock period) cycles, which is 8 at the defaults. The driven data and the address do not change while the strobe is active or on the edge where it ends.
- R5: For a read, chip select and output enable stay low with a stable address and write enable high for at least ceil(55 ns / clock period) cycles, which is 11 at the defaults, before the data is captured.
- R6: Each read produces exactly one `rsp_valid` cycle carrying the captured byte, and `rsp_valid` is never high on two consecutive cycles.
- R7: The data driver enable is never high while output enable is low. It only turns on after output enable has been high for at least ceil(20 ns / clock period) cycles, which is 4 at the defaults.
- R8: Output enable is never low while write enable is low. Write enable is only low while chip select is low.
- R9: `req_ready` is low from the cycle after a request is taken until the access and its recovery are complete. A request held valid while `req_ready` is low is taken once `req_ready` returns, and it is not lost.
- R10: During a write, chip select stays low for at least ceil(55 ns / clock period) cycles, which is 11 at the defaults.
- R11: The memory address never changes between two consecutive cycles in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read byte available |
| rsp_rdata | output | 8 | Read byte |
| sram_cs_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address bus |
| sram_dq_out | output | 8 | Value to drive on the memory data bus |
| sram_dq_oe | output | 1 | Enable for the data bus drivers |
| sram_dq_in | input | 8 | Value sampled from the memory data bus |

## Verification
The two functions that meet in one cycle are the release of the bus after a read and the start of driving for the next write. The bench provokes this by raising a write request while a read is still in progress, so the write is taken on the first idle cycle after the output-release count. The bench's memory model tracks how long output enable has been high. It counts a mismatch if the controller drives while output enable is low or before the release time has elapsed. It also returns a garbage byte to any read whose access window was too short, so a shortened read shows up as a wrong byte in the scoreboard.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACC,
    ST_RREL
  } asram_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_req_lat.sv
module asram_req_lat #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 11,
  parameter int WP_CYC  = 8,
  parameter int HLD_CYC = 2,
  parameter int HZ_CYC  = 4,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_done,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             capture,
  output logic             ready,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HLD_LD = CNT_W'(HLD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD  = CNT_W'(HZ_CYC - 1);

  asram_st_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            st_d = ST_WSET;
          end else begin
            st_d     = ST_RACC;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      ST_WSET: begin
        st_d     = ST_WPUL;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      ST_WPUL: begin
        if (cnt_done) begin
          st_d     = ST_WHLD;
          cnt_load = 1'b1;
          cnt_val  = HLD_LD;
        end
      end
      ST_WHLD: begin
        if (cnt_done) st_d = ST_IDLE;
      end
      ST_RACC: begin
        if (cnt_done) begin
          capture  = 1'b1;
          st_d     = ST_RREL;
          cnt_load = 1'b1;
          cnt_val  = HZ_LD;
        end
      end
      ST_RREL: begin
        if (cnt_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ready  = (st_q == ST_IDLE);
  assign accept = ready && req_valid;
  assign cs_n   = !(st_q == ST_WSET || st_q == ST_WPUL ||
                    st_q == ST_WHLD || st_q == ST_RACC);
  assign we_n   = (st_q != ST_WPUL);
  assign oe_n   = (st_q != ST_RACC);
  assign dq_oe  = (st_q == ST_WSET || st_q == ST_WPUL || st_q == ST_WHLD);
endmodule

// File: rtl/asram_rd_cap.sv
module asram_rd_cap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int FAST_GRADE = 1,
  parameter int AW         = 15,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  // memory limits in ns for the selected speed grade
  localparam int T_CYCLE = FAST_GRADE ? 55 : 70;
  localparam int T_ACC   = FAST_GRADE ? 55 : 70;
  localparam int T_OEACC = FAST_GRADE ? 25 : 35;
  localparam int T_PULSE = FAST_GRADE ? 40 : 50;
  localparam int T_DSET  = FAST_GRADE ? 25 : 30;
  localparam int T_CSEND = FAST_GRADE ? 45 : 60;
  localparam int T_RELZ  = FAST_GRADE ? 20 : 30;

  localparam int RD_CYC  = imax(imax(ns2cyc(T_CYCLE, CLK_NS), ns2cyc(T_ACC, CLK_NS)),
                                ns2cyc(T_OEACC, CLK_NS));
  // data and address are already valid one cycle before the strobe opens
  localparam int WP_CYC  = imax(imax(ns2cyc(T_PULSE, CLK_NS), ns2cyc(T_DSET, CLK_NS) - 1),
                                ns2cyc(T_CSEND, CLK_NS) - 1);
  localparam int HLD_CYC = imax(1, ns2cyc(T_CYCLE, CLK_NS) - 1 - WP_CYC);
  localparam int HZ_CYC  = ns2cyc(T_RELZ, CLK_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(HLD_CYC, HZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept, cnt_load, cnt_done, capture;
  logic [CNT_W-1:0] cnt_val;

  asram_req_lat #(.AW(AW), .DW(DW)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (accept),
    .addr_in (req_addr),
    .data_in (req_wdata),
    .addr_q  (sram_addr),
    .data_q  (sram_dq_out)
  );

  asram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  asram_seq #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .HLD_CYC (HLD_CYC),
    .HZ_CYC  (HZ_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cnt_done  (cnt_done),
    .accept    (accept),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .capture   (capture),
    .ready     (req_ready),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe)
  );

  asram_rd_cap #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .dq_in     (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int HZ_CYC = 4,
  parameter int WP_CYC = 8,
  parameter int AW     = 15,
  parameter int DW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          sram_cs_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe
);
  int   hz_cnt;
  int   wp_cnt;
  logic cs_low_q;
  logic we_low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hz_cnt   <= HZ_CYC;
      wp_cnt   <= 0;
      cs_low_q <= 1'b0;
      we_low_q <= 1'b0;
    end else begin
      if (!sram_oe_n)          hz_cnt <= 0;
      else if (hz_cnt < HZ_CYC) hz_cnt <= hz_cnt + 1;
      if (!sram_we_n) begin
        if (wp_cnt < WP_CYC) wp_cnt <= wp_cnt + 1;
      end else begin
        wp_cnt <= 0;
      end
      cs_low_q <= !sram_cs_n;
      we_low_q <= !sram_we_n;
    end
  end

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && hz_cnt < HZ_CYC) |-> 1'b0); // R7
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R8
  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n); // R8
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n && we_low_q) |-> (wp_cnt >= WP_CYC)); // R4
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && we_low_q) |-> $stable(sram_dq_out)); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && cs_low_q) |-> $stable(sram_addr)); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_cs_n); // R2
endmodule

bind asram_ctl asram_ctl_chk #(
  .HZ_CYC (HZ_CYC),
  .WP_CYC (WP_CYC),
  .AW     (AW),
  .DW     (DW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .sram_cs_n   (sram_cs_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_addr   (sram_addr),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/asram_ctl_tb_top.sv
module asram_ctl_tb_top;
  localparam int CLK = 5;
  function automatic int cdiv(input int ns);
    return (ns + CLK - 1) / CLK;
  endfunction
  localparam int ACC_MIN = cdiv(55);
  localparam int WP_MIN  = cdiv(40);
  localparam int WC_MIN  = cdiv(55);
  localparam int HZ_MIN  = cdiv(20);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [14:0] sram_addr;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in = 8'hEE;

  always #2.5 clk = ~clk;

  asram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0]  mem [int];
  logic [7:0]  gold [int];
  int          rd_cnt = 0, wp_cnt = 0, cs_cnt = 0, oe_hi = 100;
  logic [14:0] last_addr = '0, w_addr = '0;
  logic [7:0]  w_data = '0;
  bit          strobe_q = 0, cs_low_q = 0, wr_seen = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bool_model();
    end
  end

  task automatic bool_model();
    bit strobe, rd_mode;
    int ncnt;
    strobe  = !sram_cs_n && !sram_we_n;
    rd_mode = !sram_cs_n && !sram_oe_n && sram_we_n;
    // read access window, R5
    if (rd_mode) ncnt = (sram_addr == last_addr) ? rd_cnt + 1 : 1;
    else         ncnt = 0;
    rd_cnt = ncnt;
    if (ncnt >= ACC_MIN - 1 && mem.exists(int'(sram_addr)))
      sram_dq_in <= mem[int'(sram_addr)];
    else
      sram_dq_in <= 8'hEE;
    // write strobe, R4
    if (strobe) begin
      if (!strobe_q) begin
        wp_cnt = 1; w_addr = sram_addr; w_data = sram_dq_out; wr_seen = 1;
      end else begin
        wp_cnt++;
        check(sram_dq_out == w_data, "R4 data moved in strobe", sram_dq_out, w_data);
      end
    end else if (strobe_q) begin
      check(wp_cnt >= WP_MIN, "R4 strobe width", wp_cnt, WP_MIN);
      check(sram_dq_out == w_data && sram_addr == w_addr, "R4 hold at strobe end",
            sram_dq_out, w_data);
      mem[int'(sram_addr)] = sram_dq_out;
    end
    // chip select window, R10 and R11
    if (!sram_cs_n) begin
      if (cs_low_q)
        check(sram_addr == last_addr, "R11 address moved under select", sram_addr, last_addr);
      cs_cnt++;
    end else if (cs_low_q) begin
      if (wr_seen) check(cs_cnt >= WC_MIN, "R10 write cycle length", cs_cnt, WC_MIN);
      cs_cnt = 0; wr_seen = 0;
    end
    if (!sram_oe_n) oe_hi = 0; else oe_hi++;
    strobe_q  = strobe;
    cs_low_q  = !sram_cs_n;
    last_addr = sram_addr;
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic [7:0] exp_q [$];
  bit         rsp_q = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe) begin
        check(sram_oe_n, "R7 drive with output enable low", sram_oe_n, 1);
        check(oe_hi >= HZ_MIN, "R7 turnaround", oe_hi, HZ_MIN);
      end
      if (!sram_we_n) check(sram_oe_n && !sram_cs_n, "R8 write decode",
                            {sram_cs_n, sram_oe_n}, 2'b01);
      if (rsp_valid) begin
        check(!rsp_q, "R6 valid longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected response", rsp_rdata, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata == e, "R3/R5 read data", rsp_rdata, e);
        end
      end
      rsp_q = rsp_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input bit wr, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) gold[int'(a)] = d;
    else    exp_q.push_back(gold.exists(int'(a)) ? gold[int'(a)] : 8'hEE);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9 ready drops after accept", req_ready, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 pins in reset",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    check(req_ready && !rsp_valid, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 pins after reset",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    repeat (20) @(negedge clk);
    check(sram_cs_n && req_ready, "R2 idle standby", {sram_cs_n, req_ready}, 2'b11);

    // R3: writes at the ends and inside of the address range
    send(1, 15'h0000, 8'hA5);
    send(1, 15'h7FFF, 8'h3C);
    send(1, 15'h1234, 8'hFF);
    send(1, 15'h5555, 8'h00);
    send(0, 15'h0000, 8'h00);
    send(0, 15'h7FFF, 8'h00);
    send(0, 15'h1234, 8'h00);
    send(0, 15'h5555, 8'h00);
    // R3 overwrite, write straight into a read
    send(1, 15'h1234, 8'h81);
    send(0, 15'h1234, 8'h00);
    // R9 / R7: write raised while a read is still busy
    send(0, 15'h0000, 8'h00);
    send(1, 15'h2222, 8'h5A);
    send(0, 15'h2222, 8'h00);
    send(0, 15'h0001, 8'h00);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R6 responses outstanding", exp_q.size(), 0);
    check(sram_cs_n && req_ready, "R2 idle after traffic", {sram_cs_n, req_ready}, 2'b11);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule